// File: doc/BRIEF.md
# Opportunistic Register Scrub Controller

This block keeps a duplicated, nibble-parity-protected register file clean while the core runs. The file has a third read port that normally captures the old value of a destination register just before write-back overwrites it. In any cycle where the instruction one stage ahead of write-back will not write the file, that port is idle. The controller then reads the entry named by a rotating pointer. The register file returns per-nibble parity results for both copies of that entry in the same cycle. The controller judges each nibble. It raises a repair request when a nibble is bad in exactly one copy, and it sets a sticky flag when a nibble is bad in both copies.

A repair request names the entry and gives two nibble masks. One mask lists the nibbles of copy A that are to be overwritten from copy B. The other lists the nibbles of copy B that are to be overwritten from copy A. The request is held until the repair logic acknowledges it. While it is held, the pointer freezes and the controller issues no scrub reads. Entries whose written flag is low have no valid parity yet, so their parity results are ignored.

Top module: `rf_scrub_ctrl`

## Requirements
- R1: `scrub_rd_en_o` is high in exactly those cycles where `slot_free_i` is high and no repair request is held. `scrub_addr_o` always shows the rotating pointer, and parity results are taken in the cycle of the read.
- R2: The pointer advances by one after each cycle with `scrub_rd_en_o` high, and holds in every other cycle.
- R3: The pointer is 0 after reset, and after entry ENTRIES-1 (31 by default) it wraps to 0.
- R4: Scrubbing a written entry that has at least one nibble bad in exactly one copy raises `repair_req_o` in the next cycle. `repair_addr_o` is that entry. Bit i of `repair_fix_a_o` is set when nibble i is bad in copy A only, meaning A is overwritten from B. Bit i of `repair_fix_b_o` is set when nibble i is bad in copy B only.
- R5: Scrubbing an entry whose `written_i` bit is low raises neither a repair request nor the uncorrectable flag, whatever parity results are returned.
- R6: A held request keeps its address and masks unchanged until `repair_ack_i` is sampled high, and it is cleared in the cycle after that. An acknowledge given while no request is held has no effect.
- R7: A written entry with any nibble bad in both copies sets `uncorr_o` in the next cycle, and `uncorr_o` stays set until reset. `uncorr_addr_o` holds the first entry that set it and does not change on later such entries.
- R8: Scrubbing a written entry with no parity error raises no request.
- R9: An entry that has both single-copy and double-copy bad nibbles raises a repair request and the uncorrectable flag together. Nibbles that are bad in both copies appear in neither repair mask.
- R10: During and directly after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_free_i | input | 1 | The next write-back will not use the destination read port |
| scrub_rd_en_o | output | 1 | A scrub read is issued on the destination port this cycle |
| scrub_addr_o | output | AW (5) | Entry to read (the rotating pointer) |
| par_bad_a_i | input | NIBBLES (10) | Per-nibble parity failure of copy A for the entry being read |
| par_bad_b_i | input | NIBBLES (10) | Per-nibble parity failure of copy B for the entry being read |
| written_i | input | ENTRIES (32) | Per-entry flag: the entry has been written since power-up |
| repair_req_o | output | 1 | Nibble repair requested |
| repair_addr_o | output | AW (5) | Entry to repair |
| repair_fix_a_o | output | NIBBLES (10) | Nibbles of copy A to overwrite from copy B |
| repair_fix_b_o | output | NIBBLES (10) | Nibbles of copy B to overwrite from copy A |
| repair_ack_i | input | 1 | Repair done; releases the request |
| uncorr_o | output | 1 | Sticky: a nibble was found bad in both copies |
| uncorr_addr_o | output | AW (5) | First entry that set the sticky flag |

## Verification
Two functions can meet in one cycle: the repair request and the uncorrectable flag can be raised by the same scrub read. The bench provokes this with an entry that holds one nibble bad only in copy A and another nibble bad in both copies. It then expects the request with a mask limited to the single-copy nibble, and the sticky flag with that entry's address, both on the same clock. The acknowledge cycle is another meeting point: the bench holds `slot_free_i` high through it and expects the read to resume only one cycle after the release.

// File: rtl/rf_scrub_pkg.sv
package rf_scrub_pkg;

    // Verdict on one parity nibble, given both copies' check results
    typedef enum logic [1:0] {
        NIB_OK    = 2'd0,
        NIB_FIX_A = 2'd1,   // copy A bad, copy B good
        NIB_FIX_B = 2'd2,   // copy B bad, copy A good
        NIB_LOST  = 2'd3    // both copies bad
    } nib_verdict_e;

    function automatic nib_verdict_e judge_nibble(input logic bad_a, input logic bad_b);
        case ({bad_a, bad_b})
            2'b10:   return NIB_FIX_A;
            2'b01:   return NIB_FIX_B;
            2'b11:   return NIB_LOST;
            default: return NIB_OK;
        endcase
    endfunction

endpackage

// File: rtl/rf_scrub_nib_judge.sv
module rf_scrub_nib_judge #(
    parameter int unsigned NIBBLES = 10
) (
    input  logic [NIBBLES-1:0] bad_a_i,
    input  logic [NIBBLES-1:0] bad_b_i,
    output logic [NIBBLES-1:0] fix_a_o,
    output logic [NIBBLES-1:0] fix_b_o,
    output logic [NIBBLES-1:0] lost_o
);
    import rf_scrub_pkg::*;

    for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
        nib_verdict_e verdict;
        assign verdict    = judge_nibble(bad_a_i[g], bad_b_i[g]);
        assign fix_a_o[g] = (verdict == NIB_FIX_A);
        assign fix_b_o[g] = (verdict == NIB_FIX_B);
        assign lost_o[g]  = (verdict == NIB_LOST);
    end

endmodule

// File: rtl/rf_scrub_ptr_step.sv
module rf_scrub_ptr_step #(
    parameter int unsigned ENTRIES = 32,
    localparam int unsigned AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [AW-1:0] cur_i,
    output logic [AW-1:0] nxt_o
);
    localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1);

    assign nxt_o = (cur_i == LAST) ? '0 : cur_i + AW'(1);

endmodule

// File: rtl/rf_scrub_ctrl.sv
module rf_scrub_ctrl #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned NIBBLES = 10,
    localparam int unsigned AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               slot_free_i,
    output logic               scrub_rd_en_o,
    output logic [AW-1:0]      scrub_addr_o,
    input  logic [NIBBLES-1:0] par_bad_a_i,
    input  logic [NIBBLES-1:0] par_bad_b_i,
    input  logic [ENTRIES-1:0] written_i,
    output logic               repair_req_o,
    output logic [AW-1:0]      repair_addr_o,
    output logic [NIBBLES-1:0] repair_fix_a_o,
    output logic [NIBBLES-1:0] repair_fix_b_o,
    input  logic               repair_ack_i,
    output logic               uncorr_o,
    output logic [AW-1:0]      uncorr_addr_o
);

    typedef struct packed {
        logic [AW-1:0]      ptr;
        logic               pend;
        logic [AW-1:0]      rep_addr;
        logic [NIBBLES-1:0] fix_a;
        logic [NIBBLES-1:0] fix_b;
        logic               lost;
        logic [AW-1:0]      lost_addr;
    } scrub_state_t;

    scrub_state_t st_d, st_q;

    logic [AW-1:0]      ptr_nxt;
    logic [NIBBLES-1:0] fix_a, fix_b, lost;
    logic               rd_go;
    logic               entry_valid;

    rf_scrub_ptr_step #(.ENTRIES(ENTRIES)) u_step (
        .cur_i (st_q.ptr),
        .nxt_o (ptr_nxt)
    );

    rf_scrub_nib_judge #(.NIBBLES(NIBBLES)) u_judge (
        .bad_a_i (par_bad_a_i),
        .bad_b_i (par_bad_b_i),
        .fix_a_o (fix_a),
        .fix_b_o (fix_b),
        .lost_o  (lost)
    );

    assign rd_go       = slot_free_i && !st_q.pend;
    assign entry_valid = written_i[st_q.ptr];

    always_comb begin
        st_d = st_q;
        if (st_q.pend && repair_ack_i) begin
            st_d.pend = 1'b0;
        end
        if (rd_go) begin
            st_d.ptr = ptr_nxt;
            if (entry_valid) begin
                if (|(fix_a | fix_b)) begin
                    st_d.pend     = 1'b1;
                    st_d.rep_addr = st_q.ptr;
                    st_d.fix_a    = fix_a;
                    st_d.fix_b    = fix_b;
                end
                if ((|lost) && !st_q.lost) begin
                    st_d.lost      = 1'b1;
                    st_d.lost_addr = st_q.ptr;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scrub_rd_en_o  = rd_go;
    assign scrub_addr_o   = st_q.ptr;
    assign repair_req_o   = st_q.pend;
    assign repair_addr_o  = st_q.rep_addr;
    assign repair_fix_a_o = st_q.fix_a;
    assign repair_fix_b_o = st_q.fix_b;
    assign uncorr_o       = st_q.lost;
    assign uncorr_addr_o  = st_q.lost_addr;

endmodule

// File: rtl/rf_scrub_ctrl_chk.sv
module rf_scrub_ctrl_chk #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned NIBBLES = 10,
    localparam int unsigned AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               slot_free_i,
    input logic               scrub_rd_en_o,
    input logic [AW-1:0]      scrub_addr_o,
    input logic [ENTRIES-1:0] written_i,
    input logic               repair_req_o,
    input logic [AW-1:0]      repair_addr_o,
    input logic [NIBBLES-1:0] repair_fix_a_o,
    input logic [NIBBLES-1:0] repair_fix_b_o,
    input logic               repair_ack_i,
    input logic               uncorr_o,
    input logic [AW-1:0]      uncorr_addr_o
);
    localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1);

    AST_RD_NEEDS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scrub_rd_en_o |-> slot_free_i); // R1

    AST_NO_RD_WHILE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        repair_req_o |-> !scrub_rd_en_o); // R6

    AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scrub_rd_en_o |=> scrub_addr_o ==
            (($past(scrub_addr_o) == LAST) ? '0 : $past(scrub_addr_o) + AW'(1))); // R3

    AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !scrub_rd_en_o |=> $stable(scrub_addr_o)); // R2

    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (repair_req_o && !repair_ack_i) |=> (repair_req_o && $stable(repair_addr_o)
            && $stable(repair_fix_a_o) && $stable(repair_fix_b_o))); // R6

    AST_REQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (repair_req_o && repair_ack_i) |=> !repair_req_o); // R6

    AST_MASKS_SANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        repair_req_o |-> (((repair_fix_a_o & repair_fix_b_o) == '0)
            && ((repair_fix_a_o | repair_fix_b_o) != '0))); // R4

    AST_UNWRITTEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scrub_rd_en_o && !written_i[scrub_addr_o]) |=> (!repair_req_o && $stable(uncorr_o))); // R5

    AST_UNCORR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uncorr_o |=> (uncorr_o && $stable(uncorr_addr_o))); // R7

endmodule

bind rf_scrub_ctrl rf_scrub_ctrl_chk #(.ENTRIES(ENTRIES), .NIBBLES(NIBBLES)) u_chk (.*);

// File: tb/rf_scrub_ctrl_tb.sv
module rf_scrub_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 32;
    localparam int NIB = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            slot_free = 1'b0;
    logic            repair_ack = 1'b0;
    logic [NIB-1:0]  par_bad_a = '0;
    logic [NIB-1:0]  par_bad_b = '0;
    logic [N-1:0]    written = '0;
    logic            rd_en;
    logic [4:0]      rd_addr;
    logic            req;
    logic [4:0]      req_addr;
    logic [NIB-1:0]  fix_a, fix_b;
    logic            unc;
    logic [4:0]      unc_addr;

    rf_scrub_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .slot_free_i(slot_free),
        .scrub_rd_en_o(rd_en), .scrub_addr_o(rd_addr),
        .par_bad_a_i(par_bad_a), .par_bad_b_i(par_bad_b), .written_i(written),
        .repair_req_o(req), .repair_addr_o(req_addr),
        .repair_fix_a_o(fix_a), .repair_fix_b_o(fix_b),
        .repair_ack_i(repair_ack), .uncorr_o(unc), .uncorr_addr_o(unc_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int             m_ptr = 0;
    bit             m_pend = 0;
    int             m_raddr = 0;
    logic [NIB-1:0] m_fa = '0, m_fb = '0;
    bit             m_unc = 0;
    int             m_uaddr = 0;
    logic [NIB-1:0] ea [N];
    logic [NIB-1:0] eb [N];
    logic [N-1:0]   wr = '0;

    task automatic chk(input string req_tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare, advance model at posedge
    task automatic step(input bit slot, input bit ack);
        bit rd;
        logic [NIB-1:0] a, b;
        slot_free  = slot;
        repair_ack = ack;
        par_bad_a  = ea[m_ptr];
        par_bad_b  = eb[m_ptr];
        written    = wr;
        #1;
        chk("R1", "rd_en", int'(rd_en), int'(slot && !m_pend));
        chk("R2", "scrub addr", int'(rd_addr), m_ptr);
        chk("R6", "repair_req", int'(req), int'(m_pend));
        if (m_pend) begin
            chk("R4", "repair addr", int'(req_addr), m_raddr);
            chk("R4", "fix_a mask", int'(fix_a), int'(m_fa));
            chk("R4", "fix_b mask", int'(fix_b), int'(m_fb));
        end
        chk("R7", "uncorr", int'(unc), int'(m_unc));
        if (m_unc) chk("R7", "uncorr addr", int'(unc_addr), m_uaddr);
        @(posedge clk);
        rd = slot && !m_pend;
        if (m_pend && ack) begin
            m_pend = 0;
            ea[m_raddr] = '0;   // repaired entry now reads clean
            eb[m_raddr] = '0;
        end
        if (rd) begin
            a = ea[m_ptr];
            b = eb[m_ptr];
            if (wr[m_ptr]) begin
                if (((a & ~b) | (b & ~a)) != '0) begin
                    m_pend = 1; m_raddr = m_ptr; m_fa = a & ~b; m_fb = b & ~a;
                end
                if ((a & b) != '0 && !m_unc) begin
                    m_unc = 1; m_uaddr = m_ptr;
                end
            end
            m_ptr = (m_ptr + 1) % N;
        end
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin ea[i] = '0; eb[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R10", "rd_en in reset", int'(rd_en), 0);
        chk("R10", "repair_req in reset", int'(req), 0);
        rst_n = 1'b1;
        #1;
        chk("R10", "addr after reset", int'(rd_addr), 0);
        chk("R10", "masks after reset", int'(fix_a | fix_b), 0);
        chk("R10", "uncorr after reset", int'(unc), 0);
        chk("R10", "uncorr addr after reset", int'(unc_addr), 0);
        @(negedge clk);

        // clean, fully written file, full rotation
        wr = '1;
        for (int i = 0; i < 32; i++) step(1, 0);
        chk("R3", "wrapped to 0", int'(rd_addr), 0);
        chk("R8", "clean pass no request", int'(req), 0);
        for (int i = 0; i < 8; i++) step(1, 0);
        chk("R3", "addr after 40 reads", int'(rd_addr), 8);

        // slot available every other cycle
        for (int i = 0; i < 10; i++) step(i[0], 0);
        chk("R2", "advance only on used slots", int'(rd_addr), 13);

        // error injection
        ea[15] = 10'h004;
        wr[17] = 1'b0; ea[17] = 10'h3FF; eb[17] = 10'h155;
        ea[19] = 10'h009; eb[19] = 10'h008;
        ea[22] = 10'h020; eb[22] = 10'h020;
        eb[25] = 10'h200;

        for (int i = 0; i < 3; i++) step(1, 0);         // 13,14,15
        chk("R4", "request raised", int'(req), 1);
        chk("R4", "request entry 15", int'(req_addr), 15);
        chk("R4", "A-side mask", int'(fix_a), 10'h004);
        for (int i = 0; i < 3; i++) step(1, 0);          // held, no reads
        chk("R6", "pointer frozen", int'(rd_addr), 16);
        step(1, 1);                                       // acknowledge
        chk("R6", "released after ack", int'(req), 0);
        step(1, 0); step(1, 0);                           // 16, 17 (unwritten)
        chk("R5", "unwritten: no request", int'(req), 0);
        chk("R5", "unwritten: no uncorr", int'(unc), 0);
        step(1, 0); step(1, 0);                           // 18, 19 mixed
        chk("R9", "mixed: request", int'(req), 1);
        chk("R9", "mixed: fix_a excludes lost nibble", int'(fix_a), 10'h001);
        chk("R9", "mixed: fix_b", int'(fix_b), 0);
        chk("R9", "mixed: uncorr", int'(unc), 1);
        chk("R9", "mixed: uncorr addr", int'(unc_addr), 19);
        step(0, 1);
        for (int i = 0; i < 3; i++) step(1, 0);         // 20,21,22
        chk("R7", "sticky addr keeps first", int'(unc_addr), 19);
        step(0, 1);                                       // stray ack
        chk("R6", "stray ack no effect", int'(req), 0);
        for (int i = 0; i < 3; i++) step(1, 0);         // 23,24,25
        chk("R4", "B-side mask", int'(fix_b), 10'h200);
        chk("R4", "B-side entry", int'(req_addr), 25);
        step(1, 1);

        // mixed traffic with random injections
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 16) == 0) begin
                int e = $urandom % N;
                ea[e] = NIB'($urandom) & NIB'($urandom);
                eb[e] = NIB'($urandom) & NIB'($urandom) & NIB'($urandom);
            end
            if (($urandom % 64) == 0) wr[$urandom % N] = ~wr[$urandom % N];
            step(($urandom % 3) != 0, ($urandom % 3) == 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule